// File: doc/BRIEF.md
# Daisy-Chainable SPI Register Slave

This block is the serial control front end of an eight-channel switch controller. A host talks to it over a four-wire SPI link: chip select (active low), serial clock, serial data in and serial data out. Each 16-bit frame carries one command (diagnosis only, register read, register reset or register write) and returns the controller's 16-bit diagnosis word on serial data out. The command is decoded only when chip select is released. It is accepted only if the number of clock pulses in the frame is a nonzero multiple of eight. Every accepted frame sends out a one-cycle strobe that clears the controller's latched diagnosis flags.

The configuration registers are the input map, boolean operator, overload mode, overtemperature mode, slew mode and output control. All of them are driven as parallel outputs to the channel logic. An external output status byte can be read but not written. A read command is answered in the next frame, and that frame can itself carry a new command. Because the command is taken only at chip select release, and serial data out passes on the bits shifted in, several slaves can share one chip select in a daisy chain.

The SPI pins are sampled by the system clock through a synchronizer and edge detector. The serial clock must therefore stay well below the system clock rate.

Top module: `spi_chain_slave`

## Requirements
- R1: While cs_ni is high, so_oe_o is 0 and so_o is 0. Toggling sclk_i and si_i while cs_ni is high changes no register and produces no diag_clr_o pulse.
- R2: At the falling edge of cs_ni the shift register is loaded with diag_i, or with a pending read answer (see R7). Each rising sclk_i edge puts the next bit on so_o, MSB first. si_i is sampled on each falling sclk_i edge, MSB first.
- R3: On the rising edge of cs_ni the frame is accepted only if the count of falling sclk_i edges since cs_ni fell is a nonzero multiple of 8. Any other count discards the frame: no register change and no strobe.
- R4: The command word is laid out as cmd in bits [15:14], bits [13:11] ignored, addr in [10:8] and data in [7:0]. With cmd 11 (write), data goes to the register at addr: 1 = input map (map_o), 2 = boolean operator (bool_o), 3 = overload mode (ovl_cfg_o), 4 = overtemperature mode (ovt_cfg_o), 5 = slew mode (slew_o), 7 = output control (ctrl_o).
- R5: An rst_ni low, at any time, sets map_o to 08h and every other register to 00h.
- R6: cmd 10 returns every register to its R5 default.
- R7: cmd 01 (read) captures {01000b, addr, register content} and returns it as the SO word of the next frame. A command carried in that next frame is still executed.
- R8: cmd 00 leaves all registers unchanged.
- R9: Every accepted frame raises diag_clr_o for exactly one clk_i cycle, after cs_ni has risen.
- R10: In frames longer than 16 bits the command is taken from the last 16 bits shifted in. After the first 16 bits, so_o repeats the si_i bits in order, delayed by 16 clocks.
- R11: Writes to address 0 or 6 are ignored. A read of address 0 returns 00h. A read of address 6 returns status_i as sampled when the read frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | SPI chip select, active low |
| sclk_i | input | 1 | SPI serial clock |
| si_i | input | 1 | SPI serial data in |
| so_o | output | 1 | SPI serial data out |
| so_oe_o | output | 1 | Output enable for serial data out; 0 means high impedance |
| diag_i | input | 16 | Diagnosis word loaded at the start of a frame |
| status_i | input | 8 | Read-only output status byte |
| map_o | output | 8 | Input map register |
| bool_o | output | 8 | Boolean operator register |
| ovl_cfg_o | output | 8 | Overload mode register |
| ovt_cfg_o | output | 8 | Overtemperature mode register |
| slew_o | output | 8 | Slew mode register |
| ctrl_o | output | 8 | Output control register |
| diag_clr_o | output | 1 | One-cycle diagnosis clear strobe |

## Verification
The bench drives frames of 8, 15, 16, 17 and 24 bits. These lengths separate the accept-on-multiple-of-8 rule from a plain 16-bit count, and they show that the command is taken from the last 16 bits of a chained frame. Within each bit, si_i changes only after the rising sclk_i edge, so a design that samples on the wrong edge reads the previous bit. Back-to-back read frames with a different command in the second frame separate the delayed read answer from the diagnosis word. Writes and reads to addresses 0 and 6 cover the holes in the address map. A behavioural register model is compared with every configuration output on every clock outside the short window after each chip select release.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int FRAME_W = 16;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int NREG    = 1 << ADDR_W;

  typedef enum logic [1:0] {
    CMD_DIAG  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_RESET = 2'b10,
    CMD_WRITE = 2'b11
  } cmd_e;

  localparam logic [ADDR_W-1:0] A_NONE = 3'd0;
  localparam logic [ADDR_W-1:0] A_MAP  = 3'd1;
  localparam logic [ADDR_W-1:0] A_BOOL = 3'd2;
  localparam logic [ADDR_W-1:0] A_OVL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_OVT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_SLEW = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd6;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd7;

  localparam logic [FRAME_W-DATA_W-ADDR_W-1:0] RESP_TAG = 5'b01000;

  function automatic logic [DATA_W-1:0] reg_default(logic [ADDR_W-1:0] a);
    return (a == A_MAP) ? 8'h08 : 8'h00;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic si_i,
  output logic sel_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic si_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] cs_q, sclk_q, si_q;
  logic          cs_d, sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= '1;
      sclk_q <= '0;
      si_q   <= '0;
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_q   <= {cs_q[LAST-1:0], cs_ni};
      sclk_q <= {sclk_q[LAST-1:0], sclk_i};
      si_q   <= {si_q[LAST-1:0], si_i};
      cs_d   <= cs_q[LAST];
      sclk_d <= sclk_q[LAST];
    end
  end

  assign sel_o       = ~cs_q[LAST];
  assign cs_fall_o   = cs_d & ~cs_q[LAST];
  assign cs_rise_o   = ~cs_d & cs_q[LAST];
  // serial clock edges only count while selected
  assign sclk_rise_o = sel_o & sclk_q[LAST] & ~sclk_d;
  assign sclk_fall_o = sel_o & ~sclk_q[LAST] & sclk_d;
  assign si_o        = si_q[LAST];
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_chain_pkg::*;
#(
  parameter int COMMIT_MOD = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_fall_i,
  input  logic               sclk_rise_i,
  input  logic               sclk_fall_i,
  input  logic               si_i,
  input  logic [FRAME_W-1:0] load_i,
  output logic               so_o,
  output cmd_e               cmd_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [DATA_W-1:0]  data_o,
  output logic               frame_ok_o
);
  localparam int CNT_W = $clog2(COMMIT_MOD);

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               seen_q;
  logic               so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
      so_q   <= 1'b0;
    end else if (cs_fall_i) begin
      sr_q   <= load_i;
      cnt_q  <= '0;
      seen_q <= 1'b0;
      so_q   <= 1'b0;
    end else if (sclk_rise_i) begin
      so_q <= sr_q[FRAME_W-1];
      sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
    end else if (sclk_fall_i) begin
      sr_q[0] <= si_i;
      cnt_q   <= cnt_q + CNT_W'(1);
      seen_q  <= 1'b1;
    end
  end

  assign so_o       = so_q;
  assign cmd_o      = cmd_e'(sr_q[FRAME_W-1 -: 2]);
  assign addr_o     = sr_q[DATA_W +: ADDR_W];
  assign data_o     = sr_q[DATA_W-1:0];
  assign frame_ok_o = seen_q & (cnt_q == '0);
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_chain_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  logic               cs_fall_i,
  input  cmd_e               cmd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [DATA_W-1:0]  status_i,
  output logic               resp_pend_o,
  output logic [FRAME_W-1:0] resp_word_o,
  output logic               diag_clr_o,
  output logic [DATA_W-1:0]  map_o,
  output logic [DATA_W-1:0]  bool_o,
  output logic [DATA_W-1:0]  ovl_cfg_o,
  output logic [DATA_W-1:0]  ovt_cfg_o,
  output logic [DATA_W-1:0]  slew_o,
  output logic [DATA_W-1:0]  ctrl_o
);
  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] rd_data;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == int'(A_NONE) || g == int'(A_STAT)) begin : g_hole
      assign regs[g] = '0;
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          regs[g] <= reg_default(ADDR_W'(g));
        end else if (commit_i) begin
          if (cmd_i == CMD_RESET) regs[g] <= reg_default(ADDR_W'(g));
          else if (cmd_i == CMD_WRITE && addr_i == ADDR_W'(g)) regs[g] <= data_i;
        end
      end
    end
  end

  assign rd_data = (addr_i == A_STAT) ? status_i : regs[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_pend_o <= 1'b0;
      resp_word_o <= '0;
      diag_clr_o  <= 1'b0;
    end else begin
      diag_clr_o <= commit_i;
      if (commit_i && cmd_i == CMD_READ) begin
        resp_pend_o <= 1'b1;
        resp_word_o <= {RESP_TAG, addr_i, rd_data};
      end else if (cs_fall_i) begin
        resp_pend_o <= 1'b0;
      end
    end
  end

  assign map_o     = regs[A_MAP];
  assign bool_o    = regs[A_BOOL];
  assign ovl_cfg_o = regs[A_OVL];
  assign ovt_cfg_o = regs[A_OVT];
  assign slew_o    = regs[A_SLEW];
  assign ctrl_o    = regs[A_CTRL];
endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
  import spi_chain_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int COMMIT_MOD  = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_ni,
  input  logic        sclk_i,
  input  logic        si_i,
  output logic        so_o,
  output logic        so_oe_o,
  input  logic [15:0] diag_i,
  input  logic [7:0]  status_i,
  output logic [7:0]  map_o,
  output logic [7:0]  bool_o,
  output logic [7:0]  ovl_cfg_o,
  output logic [7:0]  ovt_cfg_o,
  output logic [7:0]  slew_o,
  output logic [7:0]  ctrl_o,
  output logic        diag_clr_o
);
  logic               sel, cs_fall, cs_rise, sclk_rise, sclk_fall, si_s;
  logic               so_bit, frame_ok, commit, resp_pend;
  logic [FRAME_W-1:0] resp_word, load_word;
  cmd_e               f_cmd;
  logic [ADDR_W-1:0]  f_addr;
  logic [DATA_W-1:0]  f_data;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i), .si_i(si_i),
    .sel_o(sel), .cs_fall_o(cs_fall), .cs_rise_o(cs_rise),
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall), .si_o(si_s)
  );

  assign load_word = resp_pend ? resp_word : diag_i;

  spi_frame_shifter #(.COMMIT_MOD(COMMIT_MOD)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_fall_i(cs_fall),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall), .si_i(si_s),
    .load_i(load_word), .so_o(so_bit),
    .cmd_o(f_cmd), .addr_o(f_addr), .data_o(f_data), .frame_ok_o(frame_ok)
  );

  assign commit = cs_rise & frame_ok;

  spi_cmd_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(commit), .cs_fall_i(cs_fall),
    .cmd_i(f_cmd), .addr_i(f_addr), .data_i(f_data), .status_i(status_i),
    .resp_pend_o(resp_pend), .resp_word_o(resp_word), .diag_clr_o(diag_clr_o),
    .map_o(map_o), .bool_o(bool_o), .ovl_cfg_o(ovl_cfg_o), .ovt_cfg_o(ovt_cfg_o),
    .slew_o(slew_o), .ctrl_o(ctrl_o)
  );

  assign so_oe_o = sel;
  assign so_o    = sel & so_bit;
endmodule

// File: rtl/spi_chain_slave_chk.sv
module spi_chain_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       so_oe_o,
  input logic [7:0] map_o,
  input logic [7:0] bool_o,
  input logic [7:0] ctrl_o,
  input logic       diag_clr_o
);
  a_r9_clr_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diag_clr_o |=> !diag_clr_o);

  a_r9_clr_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diag_clr_o |-> !so_oe_o);

  a_r3_cfg_moves_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o != $past(ctrl_o) || map_o != $past(map_o) || bool_o != $past(bool_o))
      |-> diag_clr_o);

  a_r5_default_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (map_o == 8'h08 && ctrl_o == 8'h00 && bool_o == 8'h00));

  a_r1_no_strobe_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!so_oe_o && $past(!so_oe_o) && $past(!so_oe_o, 2)) |-> !diag_clr_o);
endmodule

bind spi_chain_slave spi_chain_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .so_oe_o(so_oe_o), .map_o(map_o),
  .bool_o(bool_o), .ctrl_o(ctrl_o), .diag_clr_o(diag_clr_o)
);

// File: tb/spi_chain_slave_test.sv
module spi_chain_slave_test;
  logic clk = 1'b0;
  always #2ns clk = ~clk;

  logic        rst_ni = 1'b0, cs_ni = 1'b1, sclk = 1'b0, si = 1'b0;
  logic        so_o, so_oe_o, diag_clr_o;
  logic [15:0] diag_i = 16'h0000;
  logic [7:0]  status_i = 8'h00;
  logic [7:0]  map_o, bool_o, ovl_cfg_o, ovt_cfg_o, slew_o, ctrl_o;

  int checks = 0, errors = 0, clr_seen = 0;
  bit settle = 1'b1, done = 1'b0;
  logic [7:0]  mdl [8];
  bit          pend = 1'b0;
  logic [15:0] pw = '0;

  spi_chain_slave uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk), .si_i(si),
    .so_o(so_o), .so_oe_o(so_oe_o), .diag_i(diag_i), .status_i(status_i),
    .map_o(map_o), .bool_o(bool_o), .ovl_cfg_o(ovl_cfg_o), .ovt_cfg_o(ovt_cfg_o),
    .slew_o(slew_o), .ctrl_o(ctrl_o), .diag_clr_o(diag_clr_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void mdl_regs_default();
    for (int i = 0; i < 8; i++) mdl[i] = (i == 1) ? 8'h08 : 8'h00;
  endfunction

  function automatic logic [15:0] w(input logic [1:0] c, input logic [2:0] a, input logic [7:0] d);
    return {c, 3'b000, a, d};
  endfunction

  function automatic logic [47:0] outs();
    return {map_o, bool_o, ovl_cfg_o, ovt_cfg_o, slew_o, ctrl_o};
  endfunction

  function automatic logic [47:0] mdl_outs();
    return {mdl[1], mdl[2], mdl[3], mdl[4], mdl[5], mdl[7]};
  endfunction

  // per-clock comparison against the register model (R4)
  always @(negedge clk)
    if (rst_ni && !settle && !done)
      chk(outs() == mdl_outs(), "R4 register outputs", outs(), mdl_outs());

  always @(posedge clk) if (diag_clr_o) clr_seen++;

  task automatic half();
    repeat (8) @(posedge clk);
  endtask

  task automatic frame(input logic [47:0] bits, input int n,
                       output logic [47:0] so_cap, output logic [15:0] so_exp);
    logic [63:0] cat;
    logic [15:0] cw;
    bit acc;
    so_exp = pend ? pw : diag_i;
    pend = 1'b0;
    so_cap = '0;
    clr_seen = 0;
    cs_ni = 1'b0;
    half();
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b1;
      repeat (4) @(posedge clk);
      si = bits[i];  // changes after the rising edge: only fall sampling sees it
      repeat (4) @(posedge clk);
      #1ns so_cap[i] = so_o;
      sclk = 1'b0;
      half();
    end
    chk(so_oe_o == 1'b1, "R1 so_oe_o while selected", so_oe_o, 1);
    settle = 1'b1;
    cs_ni = 1'b1;
    repeat (12) @(posedge clk);
    acc = (n > 0) && (n % 8 == 0);
    if (acc) begin
      cat = ({48'b0, so_exp} << n) | {16'b0, bits};
      cw = cat[15:0];
      case (cw[15:14])
        2'b01: begin
          pend = 1'b1;
          pw = {5'b01000, cw[10:8], (cw[10:8] == 3'd6) ? status_i : mdl[cw[10:8]]};
        end
        2'b10: mdl_regs_default();
        2'b11: if (cw[10:8] != 3'd0 && cw[10:8] != 3'd6) mdl[cw[10:8]] = cw[7:0];
        default: ;
      endcase
    end
    chk(clr_seen == (acc ? 1 : 0), "R9 strobe count", clr_seen, acc ? 1 : 0);
    chk(so_oe_o == 1'b0 && so_o == 1'b0, "R1 released SO", {so_oe_o, so_o}, 0);
    @(negedge clk);
    settle = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [47:0] cap;
    logic [15:0] ex;
    mdl_regs_default();
    repeat (5) @(posedge clk);
    #1ns;
    // R5 reset state, R1 idle SO
    chk(outs() == mdl_outs(), "R5 reset defaults", outs(), mdl_outs());
    chk(so_oe_o == 1'b0 && diag_clr_o == 1'b0, "R1 idle after reset", {so_oe_o, diag_clr_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    settle = 1'b0;

    // R2 / R4: write output control, SO returns diag word
    diag_i = 16'h1234;
    frame(48'(w(2'b11, 3'd7, 8'hA5)), 16, cap, ex);
    chk(cap[15:0] == ex, "R2 SO diag word", cap[15:0], ex);
    chk(ctrl_o == 8'hA5, "R4 write ctrl", ctrl_o, 8'hA5);

    // R4: every writable address
    diag_i = 16'hC0DE;
    frame(48'(w(2'b11, 3'd1, 8'h3C)), 16, cap, ex);
    chk(cap[15:0] == ex, "R2 SO second pattern", cap[15:0], ex);
    frame(48'(w(2'b11, 3'd2, 8'h81)), 16, cap, ex);
    frame(48'(w(2'b11, 3'd3, 8'h7E)), 16, cap, ex);
    frame(48'(w(2'b11, 3'd4, 8'h42)), 16, cap, ex);
    frame(48'(w(2'b11, 3'd5, 8'hF0)), 16, cap, ex);
    chk(slew_o == 8'hF0 && ovl_cfg_o == 8'h7E, "R4 slew and overload", {slew_o, ovl_cfg_o}, 16'hF07E);

    // R7: read, then a write in the answering frame
    frame(48'(w(2'b01, 3'd3, 8'h00)), 16, cap, ex);
    frame(48'(w(2'b11, 3'd2, 8'h99)), 16, cap, ex);
    chk(cap[15:0] == 16'h437E, "R7 read answer", cap[15:0], 16'h437E);
    chk(bool_o == 8'h99, "R7 command in answer frame", bool_o, 8'h99);
    frame(48'(w(2'b00, 3'd0, 8'h00)), 16, cap, ex);
    chk(cap[15:0] == diag_i, "R7 answer only once", cap[15:0], diag_i);

    // R11: status read, holes ignored
    status_i = 8'hC3;
    frame(48'(w(2'b01, 3'd6, 8'h00)), 16, cap, ex);
    status_i = 8'h11;
    frame(48'(w(2'b11, 3'd6, 8'h55)), 16, cap, ex);
    chk(cap[15:0] == 16'h46C3, "R11 status read", cap[15:0], 16'h46C3);
    frame(48'(w(2'b11, 3'd0, 8'h55)), 16, cap, ex);
    frame(48'(w(2'b01, 3'd0, 8'h00)), 16, cap, ex);
    frame(48'(w(2'b00, 3'd0, 8'h00)), 16, cap, ex);
    chk(cap[15:0] == 16'h4000, "R11 read address 0", cap[15:0], 16'h4000);
    chk(outs() == mdl_outs(), "R11 holes leave registers", outs(), mdl_outs());

    // R8: diagnosis-only frame
    frame(48'(w(2'b00, 3'd7, 8'h00)), 16, cap, ex);
    chk(ctrl_o == 8'hA5, "R8 no change", ctrl_o, 8'hA5);

    // R3: discarded lengths
    frame(48'(w(2'b11, 3'd7, 8'h01) >> 1), 15, cap, ex);
    chk(ctrl_o == 8'hA5 && clr_seen == 0, "R3 15 bits discarded", ctrl_o, 8'hA5);
    frame({31'b0, w(2'b11, 3'd7, 8'h02), 1'b0}, 17, cap, ex);
    chk(ctrl_o == 8'hA5 && clr_seen == 0, "R3 17 bits discarded", ctrl_o, 8'hA5);
    diag_i = 16'h0000;
    frame(48'h00_0000_0000_5A, 8, cap, ex);
    chk(clr_seen == 1, "R3 8 bits accepted", clr_seen, 1);

    // R10: 24-bit daisy frame
    diag_i = 16'hBEEF;
    frame({24'b0, 8'h3C, w(2'b11, 3'd2, 8'h5A)}, 24, cap, ex);
    chk(cap[23:8] == 16'hBEEF, "R10 first 16 SO bits", cap[23:8], 16'hBEEF);
    chk(cap[7:0] == 8'h3C, "R10 pass-through bits", cap[7:0], 8'h3C);
    chk(bool_o == 8'h5A, "R10 last 16 bits decoded", bool_o, 8'h5A);

    // R1: SCLK/SI toggling with CS high
    clr_seen = 0;
    for (int i = 0; i < 16; i++) begin
      si = i[0];
      sclk = 1'b1; half();
      chk(so_oe_o == 1'b0, "R1 oe stays low", so_oe_o, 0);
      sclk = 1'b0; half();
    end
    chk(clr_seen == 0, "R1 no strobe unselected", clr_seen, 0);
    frame(48'(w(2'b00, 3'd0, 8'h00)), 16, cap, ex);
    chk(cap[15:0] == 16'hBEEF, "R1 shifter unaffected", cap[15:0], 16'hBEEF);

    // R6: reset command
    frame(48'(w(2'b10, 3'd0, 8'h00)), 16, cap, ex);
    chk(map_o == 8'h08 && ctrl_o == 8'h00, "R6 reset command", {map_o, ctrl_o}, 16'h0800);

    // R5: asynchronous reset mid-run
    frame(48'(w(2'b11, 3'd1, 8'hFF)), 16, cap, ex);
    settle = 1'b1;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1ns;
    mdl_regs_default();
    pend = 1'b0;
    chk(outs() == mdl_outs(), "R5 reset mid-run", outs(), mdl_outs());
    rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    settle = 1'b0;
    repeat (20) @(posedge clk);
    finish_run();
  end
endmodule